// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block models the memory-device end of a DDR3-style write leveling exchange at cycle level. A controller loads mode register 1 with the leveling enable bit set. After a settling window the device samples the level of its clock input on every qualified rising edge of the data strobe. It then returns that sample on the DQ bus after a fixed output latency. A second load of mode register 1 with the bit cleared ends the procedure. All timing counts cycles of a fast internal sampling clock `clk`. The strobe and the clock level arrive as single-bit inputs that have already been sampled.

The controller is an explicit state machine with three states. `ST_NORM` is normal operation. `ST_SETTLE` waits out the post-load window, and strobe edges are not honoured there. `ST_LEVEL` honours strobe edges. The transitions are:
- ENTER: `ST_NORM` to `ST_SETTLE` on the enabling load.
- READY: `ST_SETTLE` to `ST_LEVEL` when the settle count expires.
- EXIT: `ST_SETTLE` or `ST_LEVEL` back to `ST_NORM` on the disabling load.

The parameter `PRIME_ONLY` chooses the feedback width. When it is set, the feedback appears only on bit `PRIME_IDX` and every other bit is held low. When it is clear, the feedback is copied onto every bit.

A strobe qualifier measures every high and low phase. A short phase raises a violation pulse, and no sample is taken from it. A sample is committed once the high phase has lasted `MIN_HI` cycles. It then passes through a `T_OUT`-stage pipeline to the bus.

Top module: `wrlvl_responder`

## Requirements
- R1: A synchronous active-high `rst` returns the block to `ST_NORM` with `dq_oe`=0, `dq`=0, `cmd_err`=0 and `pw_err`=0.
- R2: A clock edge with `cmd`=2 (mode register load), `mr_sel`=1 and `lvl_en_bit`=1, taken in `ST_NORM`, enters leveling. Call that edge M. `dq_oe` rises after edge M+`T_OE`. `dq` stays 0 until the first sample is delivered.
- R3: A strobe rising edge seen at a clock edge no later than M+`T_MRD` is ignored and produces no feedback.
- R4: An honoured strobe rise at edge E captures `ck_lvl`. The value appears on `dq` after edge E+`MIN_HI`+`T_OUT` and holds until the next delivered sample.
- R5: With `PRIME_ONLY`=1, `dq[PRIME_IDX]` carries the feedback and every other bit is 0 at all times.
- R6: With `PRIME_ONLY`=0, every `dq` bit carries the same feedback value.
- R7: In `ST_LEVEL`, a strobe high phase shorter than `MIN_HI` cycles gives a one-cycle `pw_err` pulse, and its capture is dropped.
- R8: In `ST_LEVEL`, a strobe rise whose preceding low phase is shorter than `MIN_LO` cycles gives a one-cycle `pw_err` pulse and is not sampled.
- R9: While leveling, any `cmd` other than 0 (NOP), 1 (deselect) or the disabling load sets `cmd_err` for the one cycle after that edge. The mode is left unchanged.
- R10: A load with `cmd`=2, `mr_sel`=1 and `lvl_en_bit`=0, taken while leveling, returns the block to `ST_NORM`. `dq_oe` and `dq` go to 0 after that edge, and any sample still in flight is discarded.
- R11: In `ST_NORM`, strobe pulses and commands other than the enabling load have no effect on `dq`, `dq_oe`, `cmd_err` or `pw_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command: 0 NOP, 1 deselect, 2 mode load, 3..7 other |
| mr_sel | input | 2 | Target mode register of a mode load |
| lvl_en_bit | input | 1 | Leveling enable bit carried by the mode load |
| dqs | input | 1 | Sampled data strobe level |
| ck_lvl | input | 1 | Sampled clock level to be captured |
| dq | output | DQ_W | Feedback data bus |
| dq_oe | output | 1 | DQ output enable |
| cmd_err | output | 1 | Illegal command seen while leveling (one-cycle pulse) |
| pw_err | output | 1 | Strobe pulse-width violation (one-cycle pulse) |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and stable across each rising edge.
- `MIN_HI` is at least 2 and `T_OE` does not exceed the earliest possible feedback time, so `dq` is never nonzero while `dq_oe` is low.

The stimulus changes every input only on the falling edge of `clk`. It uses only listed command codes. It spaces strobe pulses far enough apart that each pulse's outcome settles before the next begins. Short pulses appear only where a violation is the intended result.

// File: rtl/wrl_pkg.sv
package wrl_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_DESEL = 3'd1,
        CMD_MRS   = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_WR    = 3'd4,
        CMD_RD    = 3'd5,
        CMD_PRE   = 3'd6,
        CMD_REF   = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_NORM   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LEVEL  = 2'd2
    } lvl_st_e;

    localparam logic [1:0] MR_LVL = 2'd1;

endpackage

// File: rtl/wrl_strobe_qual.sv
// Measures strobe phases, captures the clock level on a qualified rise and
// commits it once the high phase has lasted MIN_HI cycles (MIN_HI >= 2).
module wrl_strobe_qual #(
    parameter int MIN_HI = 2,
    parameter int MIN_LO = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dqs,
    input  logic ck_lvl,
    output logic smp_vld,
    output logic smp_bit,
    output logic runt
);
    localparam int MAXW = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
    localparam int CW   = $clog2(MAXW + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic          dqs_q;
    logic [CW-1:0] run_q;
    logic          armed_q;
    logic          cap_q;
    logic          rise, fall, lo_ok, hi_ok, commit;

    always_comb begin
        rise   = dqs & ~dqs_q;
        fall   = ~dqs & dqs_q;
        lo_ok  = run_q >= CW'(MIN_LO);
        hi_ok  = run_q >= CW'(MIN_HI);
        commit = en & armed_q & dqs & dqs_q & (run_q == CW'(MIN_HI - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_q   <= 1'b0;
            run_q   <= CMAX;
            armed_q <= 1'b0;
            cap_q   <= 1'b0;
            smp_vld <= 1'b0;
            smp_bit <= 1'b0;
            runt    <= 1'b0;
        end else begin
            dqs_q <= dqs;
            if (rise || fall)
                run_q <= CW'(1);
            else if (run_q != CMAX)
                run_q <= run_q + CW'(1);
            smp_vld <= commit;
            if (commit)
                smp_bit <= cap_q;
            runt <= 1'b0;
            if (!en) begin
                armed_q <= 1'b0;
            end else if (rise) begin
                if (lo_ok) begin
                    armed_q <= 1'b1;
                    cap_q   <= ck_lvl;
                end else begin
                    armed_q <= 1'b0;
                    runt    <= 1'b1;
                end
            end else if (commit) begin
                armed_q <= 1'b0;
            end else if (fall && !hi_ok) begin
                armed_q <= 1'b0;
                runt    <= 1'b1;
            end
        end
    end

    // R4
    sample_src_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ($past(dqs) && $past(en)));

    // R7
    runt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        runt |-> !smp_vld);

endmodule

// File: rtl/wrl_fb_pipe.sv
// Fixed-latency feedback pipeline with a synchronous discard (DEPTH >= 1).
module wrl_fb_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic in_vld,
    input  logic in_bit,
    output logic out_vld,
    output logic out_bit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic v_q;
        logic b_q;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    v_q <= 1'b0;
                    b_q <= 1'b0;
                end else begin
                    v_q <= in_vld;
                    b_q <= in_bit;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    v_q <= 1'b0;
                    b_q <= 1'b0;
                end else begin
                    v_q <= g_stage[i-1].v_q;
                    b_q <= g_stage[i-1].b_q;
                end
            end
        end
    end

    assign out_vld = g_stage[DEPTH-1].v_q;
    assign out_bit = g_stage[DEPTH-1].b_q;

    // R10
    flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_vld);

endmodule

// File: rtl/wrlvl_responder.sv
module wrlvl_responder
    import wrl_pkg::*;
#(
    parameter int DQ_W       = 8,
    parameter bit PRIME_ONLY = 1'b1,
    parameter int PRIME_IDX  = 0,
    parameter int MIN_HI     = 2,
    parameter int MIN_LO     = 2,
    parameter int T_MRD      = 8,
    parameter int T_OE       = 4,
    parameter int T_OUT      = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cmd,
    input  logic [1:0]      mr_sel,
    input  logic            lvl_en_bit,
    input  logic            dqs,
    input  logic            ck_lvl,
    output logic [DQ_W-1:0] dq,
    output logic            dq_oe,
    output logic            cmd_err,
    output logic            pw_err
);
    localparam int AGE_MAX = (T_MRD > T_OE) ? T_MRD : T_OE;
    localparam int AW      = $clog2(AGE_MAX + 1);
    localparam logic [DQ_W-1:0] PRIME_MASK = DQ_W'(1) << PRIME_IDX;

    lvl_st_e       st_q, st_d;
    logic [AW-1:0] age_q;
    cmd_e          cmd_c;
    logic          is_mr1, enter, leave, benign, in_mode, oe_hit;
    logic          qual_en, smp_vld, smp_bit, runt;
    logic          fb_vld, fb_bit;
    logic [DQ_W-1:0] fb_word;

    always_comb begin
        cmd_c   = cmd_e'(cmd);
        is_mr1  = (cmd_c == CMD_MRS) && (mr_sel == MR_LVL);
        enter   = is_mr1 & lvl_en_bit;
        leave   = is_mr1 & ~lvl_en_bit;
        benign  = (cmd_c == CMD_NOP) || (cmd_c == CMD_DESEL);
        in_mode = (st_q != ST_NORM);
        oe_hit  = in_mode && !leave && (age_q == AW'(T_OE - 1));
        qual_en = (st_q == ST_LEVEL);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_NORM:   if (enter) st_d = ST_SETTLE;
            ST_SETTLE: if (leave) st_d = ST_NORM;
                       else if (age_q == AW'(T_MRD - 1)) st_d = ST_LEVEL;
            ST_LEVEL:  if (leave) st_d = ST_NORM;
            default:   st_d = ST_NORM;
        endcase
    end

    // state register and entry age counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_NORM;
            age_q <= '0;
        end else begin
            st_q <= st_d;
            if (!in_mode)
                age_q <= '0;
            else if (age_q != AW'(AGE_MAX))
                age_q <= age_q + AW'(1);
        end
    end

    wrl_strobe_qual #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_qual (
        .clk(clk), .rst(rst), .en(qual_en), .dqs(dqs), .ck_lvl(ck_lvl),
        .smp_vld(smp_vld), .smp_bit(smp_bit), .runt(runt)
    );

    wrl_fb_pipe #(.DEPTH(T_OUT)) u_pipe (
        .clk(clk), .rst(rst), .flush(in_mode & leave),
        .in_vld(smp_vld), .in_bit(smp_bit),
        .out_vld(fb_vld), .out_bit(fb_bit)
    );

    if (PRIME_ONLY) begin : g_prime
        assign fb_word = fb_bit ? PRIME_MASK : '0;
    end else begin : g_all
        assign fb_word = {DQ_W{fb_bit}};
    end

    assign pw_err = runt;

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dq      <= '0;
            dq_oe   <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= in_mode & ~benign & ~leave;
            if (!in_mode || leave) begin
                dq    <= '0;
                dq_oe <= 1'b0;
            end else begin
                if (oe_hit)
                    dq_oe <= 1'b1;
                if (fb_vld)
                    dq <= fb_word;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!dq_oe && dq == '0 && !cmd_err));

    // R10
    exit_off_chk: assert property (@(posedge clk) disable iff (rst)
        (in_mode && leave) |=> (!dq_oe && dq == '0));

    // R9
    cmd_err_mode_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(st_q != ST_NORM));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_NORM && $past(st_q == ST_NORM)) |-> (!dq_oe && !pw_err && dq == '0));

    // R2
    oe_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (dq != '0) |-> dq_oe);

    if (PRIME_ONLY) begin : g_prime_chk
        // R5
        prime_only_chk: assert property (@(posedge clk) disable iff (rst)
            (dq & ~PRIME_MASK) == '0);
    end

endmodule

// File: tb/sim_wrlvl_responder.sv
`timescale 1ns/1ps
module sim_wrlvl_responder;
    localparam int W   = 8;
    localparam int MH  = 2;
    localparam int ML  = 2;
    localparam int TM  = 8;
    localparam int TO  = 4;
    localparam int TD  = 3;
    localparam int LAT = MH + TD;
    // vector: [4] clock level, [3:0] strobe high width in cycles
    localparam logic [4:0] VEC [8] = '{5'h14, 5'h03, 5'h11, 5'h12,
                                       5'h01, 5'h02, 5'h16, 5'h11};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [1:0] mr_sel = 2'd0;
    logic lvl_en_bit = 1'b0;
    logic dqs = 1'b0;
    logic ck_lvl = 1'b0;
    logic [W-1:0] dq, dq1;
    logic dq_oe, oe1, cmd_err, ce1, pw_err, pe1;
    int n_chk = 0;
    int n_bad = 0;
    int pw_cnt = 0;
    logic cur = 1'b0;

    always #2.5 clk = ~clk;

    wrlvl_responder #(.DQ_W(W), .PRIME_ONLY(1'b1), .PRIME_IDX(0), .MIN_HI(MH),
        .MIN_LO(ML), .T_MRD(TM), .T_OE(TO), .T_OUT(TD)) u0 (
        .clk(clk), .rst(rst), .cmd(cmd), .mr_sel(mr_sel), .lvl_en_bit(lvl_en_bit),
        .dqs(dqs), .ck_lvl(ck_lvl), .dq(dq), .dq_oe(dq_oe), .cmd_err(cmd_err),
        .pw_err(pw_err));

    wrlvl_responder #(.DQ_W(W), .PRIME_ONLY(1'b0), .PRIME_IDX(0), .MIN_HI(MH),
        .MIN_LO(ML), .T_MRD(TM), .T_OE(TO), .T_OUT(TD)) u1 (
        .clk(clk), .rst(rst), .cmd(cmd), .mr_sel(mr_sel), .lvl_en_bit(lvl_en_bit),
        .dqs(dqs), .ck_lvl(ck_lvl), .dq(dq1), .dq_oe(oe1), .cmd_err(ce1),
        .pw_err(pe1));

    always @(negedge clk) if (pw_err) pw_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pw0;
        step(3);
        check("R1 dq", 32'(dq), 0);
        check("R1 oe", 32'(dq_oe), 0);
        check("R1 flags", {30'd0, cmd_err, pw_err}, 0);
        rst = 1'b0;
        step(2);

        // R11: normal mode ignores strobes and commands
        pw0 = pw_cnt;
        ck_lvl = 1'b1; dqs = 1'b1; step(4); dqs = 1'b0; step(LAT + 4);
        cmd = 3'd3; step(1);
        check("R11 cmd_err", 32'(cmd_err), 0);
        cmd = 3'd0; step(1);
        check("R11 dq", 32'(dq), 0);
        check("R11 oe", 32'(dq_oe), 0);
        check("R11 pw", 32'(pw_cnt - pw0), 0);

        // R2: entry, edge M
        cmd = 3'd2; mr_sel = 2'd1; lvl_en_bit = 1'b1; step(1);
        cmd = 3'd0; lvl_en_bit = 1'b0;
        step(TO - 1);
        check("R2 oe early", 32'(dq_oe), 0);
        step(1);
        check("R2 oe on", 32'(dq_oe), 1);
        check("R2 dq low", 32'(dq), 0);

        // R3: rise at edge M+TM is ignored
        step(TM - TO - 1);
        ck_lvl = 1'b1; dqs = 1'b1; step(LAT + 3);
        check("R3 dq", 32'(dq), 0);
        check("R3 dq all", 32'(dq1), 0);
        dqs = 1'b0; step(6);

        // R4: exact latency
        ck_lvl = 1'b1; dqs = 1'b1; step(LAT);
        check("R4 before", 32'(dq), 0);
        step(1);
        check("R4 prime", 32'(dq), 32'h01);
        check("R6 all", 32'(dq1), 32'hFF);
        dqs = 1'b0; step(6);
        cur = 1'b1;

        // vector table: R5, R6, R7
        for (int i = 0; i < 8; i++) begin
            pw0 = pw_cnt;
            ck_lvl = VEC[i][4];
            dqs = 1'b1; step(int'(VEC[i][3:0]));
            dqs = 1'b0; step(LAT + ML + 3);
            if (int'(VEC[i][3:0]) >= MH) cur = VEC[i][4];
            check("R5 prime word", 32'(dq), cur ? 32'h01 : 32'h00);
            check("R6 all word", 32'(dq1), cur ? 32'hFF : 32'h00);
            check("R7 runt count", 32'(pw_cnt - pw0), (int'(VEC[i][3:0]) < MH) ? 1 : 0);
        end

        // R8: short low phase before a rise
        pw0 = pw_cnt;
        ck_lvl = 1'b1; dqs = 1'b1; step(3);
        dqs = 1'b0; step(1);
        ck_lvl = 1'b0; dqs = 1'b1; step(LAT + 3);
        check("R8 pw", 32'(pw_cnt - pw0), 1);
        check("R8 dq kept", 32'(dq), 32'h01);
        dqs = 1'b0; step(6);

        // R9: illegal command while leveling
        cmd = 3'd3; step(1);
        check("R9 cmd_err", 32'(cmd_err), 1);
        cmd = 3'd0; step(1);
        check("R9 clear", 32'(cmd_err), 0);
        check("R9 mode kept", 32'(dq_oe), 1);

        // R10: exit with a sample in flight
        ck_lvl = 1'b0; dqs = 1'b1; step(2);
        cmd = 3'd2; mr_sel = 2'd1; lvl_en_bit = 1'b0; step(1);
        cmd = 3'd0;
        check("R10 oe", 32'(dq_oe), 0);
        check("R10 dq", 32'(dq), 0);
        step(LAT + 2);
        check("R10 discard", 32'(dq), 0);
        check("R10 discard all", 32'(dq1), 0);
        dqs = 1'b0; step(3);

        // R11 after exit
        pw0 = pw_cnt;
        ck_lvl = 1'b1; dqs = 1'b1; step(1); dqs = 1'b0; step(LAT + 4);
        check("R11 post exit dq", 32'(dq), 0);
        check("R11 post exit pw", 32'(pw_cnt - pw0), 0);

        // R1: reset while leveling
        cmd = 3'd2; lvl_en_bit = 1'b1; step(1);
        cmd = 3'd0; lvl_en_bit = 1'b0; step(TO + 2);
        check("R2 oe re-entry", 32'(dq_oe), 1);
        rst = 1'b1; step(1);
        check("R1 oe reset", 32'(dq_oe), 0);
        rst = 1'b0; step(TO + 2);
        check("R1 stays normal", 32'(dq_oe), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule